// File: doc/BRIEF.md
# Serial Increment/Decrement Wiper Stepper

This block runs the streaming adjust mode of a digitally controlled potentiometer's two-wire slave. The bus front end decodes the adjust opcode and acknowledges it. It then raises `enterStep` for one cycle while SCL is low. From that point the stepper owns the bus. Each SCL high pulse moves the 8-bit wiper by one tap. The level of SDA during that pulse gives the direction: high moves toward the high terminal (+1), low moves toward the low terminal (-1). Up and down pulses may be mixed in any number. There is no byte framing and there are no acknowledges.

When stepping begins, the block takes a snapshot of the live wiper value. It keeps a working copy of that value and reports every move on a direct update port: `wiperNext` carries the value and `wiperWrite` pulses for one cycle. A START or STOP condition ends the mode, meaning any SDA change while SCL is high. The block then pulses `stepDone` and hands control back to the front end. SCL and SDA arrive already synchronised to `clk`. The block never drives SDA.

A step is captured when SCL rises and is committed when SCL falls. A pulse whose high phase contains a START or STOP therefore never moves the wiper. This covers the SCL rise that opens a STOP condition.

Top module: `wiper_stepper`

## Requirements
- R1: After reset, `stepActive`, `wiperWrite` and `stepDone` are 0 and `wiperNext` is 0.
- R2: In idle, `enterStep`=1 at a clock edge sets `stepActive` from the next cycle and loads the working value from `wiperCur`. `wiperNext` shows that value from the next cycle.
- R3: While active, an SCL high pulse with SDA=1 sampled at the rising edge gives a one-cycle `wiperWrite` in the cycle after the falling edge is sampled. `wiperNext` = previous value + 1.
- R4: As R3, but with SDA=0 sampled at the rising edge the new value is previous - 1.
- R5: Stepping saturates. An up step at 255 leaves 255 and a down step at 0 leaves 0. `wiperWrite` still pulses in both cases.
- R6: While active, an SDA change while SCL stays high (SDA rising = STOP, SDA falling = START) produces no step. It clears `stepActive` and gives a one-cycle `stepDone` in the following cycle.
- R7: While idle, SCL/SDA activity produces no `wiperWrite` and leaves `wiperNext` unchanged.
- R8: An SCL high phase of any length gives exactly one step.
- R9: `enterStep` while already active is ignored: `wiperNext` does not reload.
- R10: Up and down steps can be mixed in one session. Each applies in order to the running value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enterStep | input | 1 | Front end: adjust opcode acknowledged, begin stepping |
| sclIn | input | 1 | Synchronised SCL |
| sdaIn | input | 1 | Synchronised SDA |
| wiperCur | input | WIDTH | Live wiper value, snapshotted on entry |
| wiperNext | output | WIDTH | Working wiper value to write |
| wiperWrite | output | 1 | One-cycle strobe: write `wiperNext` to the wiper |
| stepActive | output | 1 | Stepping mode owns the bus |
| stepDone | output | 1 | One-cycle pulse when a START/STOP ends stepping |

## Verification
A corrupted working value shows on `wiperNext` in the same cycle, because that port always exposes the working value. A lost or latched direction shows at the next `wiperWrite` as a step of the wrong sign. A stale pending flag shows as a spurious write after a STOP, one cycle after SCL falls. An activity flag stuck in the wrong state shows within one SCL pulse: the write appears or goes missing, and `stepDone` shows it on the cycle after the bus condition. The bench compares every output against a behavioural model on every cycle, so any of these faults is reported in the cycle it first becomes visible.

// File: rtl/wiper_step_pkg.sv
package wiper_step_pkg;
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } stepCtl_t;
endpackage

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
  import wiper_step_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enterStep,
  input  logic     sclIn,
  input  logic     sdaIn,
  output stepCtl_t ctl,
  output logic     stepActive,
  output logic     stepDone
);
  logic sclQ, sdaQ, activeQ, pendQ, dirQ, doneQ;
  logic sclRise, sclFall, busCond;

  assign sclRise = sclIn & ~sclQ;
  assign sclFall = ~sclIn & sclQ;
  // SDA moving while SCL is held high marks START or STOP
  assign busCond = sclIn & sclQ & (sdaIn ^ sdaQ);

  always_comb begin
    ctl.load = ~activeQ & enterStep;
    ctl.inc  = activeQ & sclFall & pendQ & dirQ;
    ctl.dec  = activeQ & sclFall & pendQ & ~dirQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      activeQ <= 1'b0;
      pendQ   <= 1'b0;
      dirQ    <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      sclQ  <= sclIn;
      sdaQ  <= sdaIn;
      doneQ <= activeQ & busCond;
      if (!activeQ) begin
        activeQ <= enterStep;
        pendQ   <= 1'b0;
      end else if (busCond) begin
        activeQ <= 1'b0;
        pendQ   <= 1'b0;
      end else if (sclRise) begin
        pendQ <= 1'b1;
        dirQ  <= sdaIn;
      end else if (sclFall) begin
        pendQ <= 1'b0;
      end
    end
  end

  assign stepActive = activeQ;
  assign stepDone   = doneQ;
endmodule

// File: rtl/wiper_step_dp.sv
module wiper_step_dp
  import wiper_step_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCtl_t         ctl,
  input  logic [WIDTH-1:0] wiperCur,
  output logic [WIDTH-1:0] wiperNext,
  output logic             wiperWrite
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] workQ;
  logic             writeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workQ  <= BOT;
      writeQ <= 1'b0;
    end else begin
      writeQ <= ctl.inc | ctl.dec;
      if (ctl.load)
        workQ <= wiperCur;
      else if (ctl.inc && workQ != TOP)
        workQ <= workQ + ONE;
      else if (ctl.dec && workQ != BOT)
        workQ <= workQ - ONE;
    end
  end

  assign wiperNext  = workQ;
  assign wiperWrite = writeQ;
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
  import wiper_step_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enterStep,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [WIDTH-1:0] wiperCur,
  output logic [WIDTH-1:0] wiperNext,
  output logic             wiperWrite,
  output logic             stepActive,
  output logic             stepDone
);
  stepCtl_t ctl;

  wiper_step_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enterStep(enterStep), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .stepActive(stepActive), .stepDone(stepDone)
  );

  wiper_step_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wiperCur(wiperCur),
    .wiperNext(wiperNext), .wiperWrite(wiperWrite)
  );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] wiperNext,
  input logic             wiperWrite,
  input logic             stepActive,
  input logic             stepDone
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rstN)
    (wiperWrite && $past(wiperNext) != TOP && $past(wiperNext) != '0) |->
      (wiperNext == $past(wiperNext) + ONE || wiperNext == $past(wiperNext) - ONE)); // R3
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (wiperWrite && $past(wiperNext) == TOP) |-> wiperNext != '0); // R5
  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rstN)
    (wiperWrite && $past(wiperNext) == '0) |-> wiperNext != TOP); // R5
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wiperWrite |=> !wiperWrite); // R8
  AST_WRITE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    wiperWrite |-> $past(stepActive)); // R7
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |-> (!stepActive && $past(stepActive))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |=> !stepDone); // R6
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (stepActive && $past(stepActive) && !wiperWrite) |-> $stable(wiperNext)); // R9
endmodule

bind wiper_stepper wiper_stepper_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .wiperNext(wiperNext), .wiperWrite(wiperWrite),
  .stepActive(stepActive), .stepDone(stepDone)
);

// File: tb/wiper_stepper_bench.sv
module wiper_stepper_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enterStep = 1'b0;
  logic       sclIn = 1'b1;
  logic       sdaIn = 1'b1;
  logic [7:0] wiperCur = 8'd0;
  logic [7:0] wiperNext;
  logic       wiperWrite, stepActive, stepDone;

  int    errors = 0;
  int    checks = 0;
  string reqTag = "R1";
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  wiper_stepper u_wiper_stepper (
    .clk(clk), .rstN(rstN), .enterStep(enterStep), .sclIn(sclIn), .sdaIn(sdaIn),
    .wiperCur(wiperCur), .wiperNext(wiperNext), .wiperWrite(wiperWrite),
    .stepActive(stepActive), .stepDone(stepDone)
  );

  // behavioural reference
  int mWiper = 0;
  bit mActive = 0, mWrite = 0, mDone = 0, mPend = 0, mDir = 0, mScl = 1, mSda = 1;
  always @(posedge clk) begin
    bit w, d;
    w = 0; d = 0;
    if (!rstN) begin
      mWiper = 0; mActive = 0; mPend = 0; mDir = 0; mScl = 1; mSda = 1;
    end else begin
      if (!mActive) begin
        mPend = 0;
        if (enterStep) begin mActive = 1; mWiper = wiperCur; end
      end else if (mScl && sclIn && (mSda != sdaIn)) begin
        mActive = 0; mPend = 0; d = 1;
      end else if (!mScl && sclIn) begin
        mPend = 1; mDir = sdaIn;
      end else if (mScl && !sclIn && mPend) begin
        mPend = 0; w = 1;
        if (mDir) mWiper = (mWiper == 255) ? 255 : mWiper + 1;
        else      mWiper = (mWiper == 0) ? 0 : mWiper - 1;
      end else if (mScl && !sclIn) begin
        mPend = 0;
      end
      mScl = sclIn; mSda = sdaIn;
    end
    mWrite = w; mDone = d;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk({reqTag, " wiperNext"}, wiperNext, mWiper);
      chk({reqTag, " wiperWrite"}, wiperWrite, mWrite);
      chk({reqTag, " stepActive"}, stepActive, mActive);
      chk({reqTag, " stepDone"}, stepDone, mDone);
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit dir, int high);
    sdaIn = dir; waitN(1);
    sclIn = 1'b1; waitN(high);
    sclIn = 1'b0; waitN(2);
  endtask

  task automatic enter(int v);
    sclIn = 1'b0; waitN(1);
    wiperCur = 8'(v); enterStep = 1'b1; waitN(1);
    enterStep = 1'b0; waitN(1);
  endtask

  task automatic stopCond();
    sdaIn = 1'b0; waitN(1);
    sclIn = 1'b1; waitN(2);
    sdaIn = 1'b1; waitN(3);
  endtask

  task automatic startCond();
    sdaIn = 1'b1; waitN(1);
    sclIn = 1'b1; waitN(2);
    sdaIn = 1'b0; waitN(3);
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    chk("R1 reset active", stepActive, 0);
    chk("R1 reset write", wiperWrite, 0);
    chk("R1 reset done", stepDone, 0);
    chk("R1 reset wiper", wiperNext, 0);

    reqTag = "R7";
    sclIn = 1'b0; waitN(1);
    pulse(1, 2); pulse(0, 3); pulse(1, 1);
    chk("R7 idle wiper unchanged", wiperNext, 0);

    reqTag = "R2";
    enter(100);
    chk("R2 active after entry", stepActive, 1);
    chk("R2 snapshot", wiperNext, 100);

    reqTag = "R3";
    pulse(1, 2); pulse(1, 2); pulse(1, 3);
    chk("R3 three ups", wiperNext, 103);

    reqTag = "R4";
    repeat (5) pulse(0, 2);
    chk("R4 five downs", wiperNext, 98);

    reqTag = "R10";
    pulse(1, 1); pulse(0, 1); pulse(0, 2); pulse(1, 1); pulse(1, 1); pulse(1, 2);
    chk("R10 mixed", wiperNext, 100);

    reqTag = "R8";
    pulse(1, 9);
    chk("R8 long high is one step", wiperNext, 101);

    reqTag = "R9";
    wiperCur = 8'd7; enterStep = 1'b1; waitN(1); enterStep = 1'b0; waitN(2);
    chk("R9 no reload", wiperNext, 101);

    reqTag = "R6";
    stopCond();
    chk("R6 stop ends mode", stepActive, 0);
    chk("R6 stop no step", wiperNext, 101);

    reqTag = "R7";
    sclIn = 1'b0; waitN(1);
    pulse(0, 2); pulse(1, 2);
    chk("R7 idle after stop", wiperNext, 101);

    reqTag = "R5";
    enter(253);
    repeat (4) pulse(1, 2);
    chk("R5 top saturate", wiperNext, 255);
    reqTag = "R6";
    stopCond();

    reqTag = "R5";
    enter(1);
    repeat (3) pulse(0, 2);
    chk("R5 bottom saturate", wiperNext, 0);

    reqTag = "R6";
    startCond();
    chk("R6 start ends mode", stepActive, 0);
    chk("R6 start no step", wiperNext, 0);

    waitN(2);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule